// File: doc/BRIEF.md
# Watchdog-capable timer channel

A single 16-bit up-counting timer channel that a supervisor can turn into a watchdog. A slow reference tick, or the core clock, goes through a power-of-two prescaler. Each prescaled tick advances the counter. When an armed counter steps onto the compare value, the channel latches a sticky event and stops there. Two per-channel enable inputs pass that event on as a reset request and as a non-maskable interrupt request.

Software talks to the channel through a 16-bit register port with three registers: compare, counter and setup. The setup register may be configured once after reset. After that, the prescaler, clock choice and compare arming are frozen. Only the run bit and the write-1-to-clear event bit can still be changed. A watchdog is serviced by clearing the run bit, writing the counter, clearing the event and setting the run bit again. A channel that has never been configured reads back zero in setup, so software can tell that it is free.

Top module: `wdt_timer_chan`

## Requirements
- R1: After reset, every register (address 0 compare, 1 counter, 2 setup) reads 0, address 3 always reads 0, and both request outputs are low.
- R2: The first write to setup after reset stores the prescale code (bits 3:0), the clock select (bit 4) and the compare arm (bit 5), and sets the read-only lock flag (bit 12). Later setup writes leave bits 5:0 unchanged until reset.
- R3: The run bit (setup bit 15) takes the written value on every setup write, whether the lock flag is set or not.
- R4: While the run bit is 0, the counter holds its value.
- R5: While running, the counter advances by one for every 2^code source ticks. The source is the ref_tick input when bit 4 is 0 and every clock cycle when bit 4 is 1. Without source ticks the counter does not move.
- R6: Writing the counter loads any 16-bit value, including 0, and restarts the prescale division. The first increment then comes 2^code source ticks later.
- R7: When armed, the tick that brings the counter to the compare value sets the event flag (setup bit 14) in the same cycle. The counter then stays at that value, and the event does not fire again, until the counter is written.
- R8: The event flag stays set until a setup write with bit 14 equal to 1. A setup write with bit 14 equal to 0 leaves it set.
- R9: rst_req is high exactly while the event flag is set and reset_en is 1.
- R10: nmi_req is high exactly while the event flag is set and nmi_en is 1.
- R11: When not armed, the counter runs freely, wraps from 0xFFFF to 0, and never sets the event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulses of the slow reference |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 compare, 1 counter, 2 setup |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| reset_en | input | 1 | Lets the event drive rst_req |
| nmi_en | input | 1 | Lets the event drive nmi_req |
| rst_req | output | 1 | Reset request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The counting path is swept over prescale codes 0 to 7 with the core clock as the source. At each code the counter is checked one cycle before the compare value is reached and again at the moment it is reached. This shows whether the division is exact and whether the event appears in the same cycle as the final increment. A separate run drives sparse reference pulses, with long gaps between them, to show that only source ticks count. An unarmed run passes through the compare value and over 0xFFFF to check the wrap and that no event fires. After an event, the bench varies the two enable inputs, sends setup writes with and without the clear bit, rewrites the counter and clears the run bit. This separates the hold behaviour, the event lock, the clear, and the freezing of the configuration fields.

// File: rtl/wdt_chan_pkg.sv
package wdt_chan_pkg;

    localparam int DATA_W = 16;
    localparam int PSC_W  = 4;
    localparam int DIV_W  = (1 << PSC_W) - 1;

    localparam int SB_RUN  = 15;
    localparam int SB_EVT  = 14;
    localparam int SB_LOCK = 12;
    localparam int SB_ARM  = 5;
    localparam int SB_FAST = 4;

    typedef enum logic [1:0] {
        REG_CMP   = 2'd0,
        REG_CNT   = 2'd1,
        REG_SETUP = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             arm;
        logic             fast_clk;
        logic [PSC_W-1:0] psc;
    } setup_cfg_t;

    function automatic setup_cfg_t decode_cfg(input logic [DATA_W-1:0] w);
        setup_cfg_t c;
        c.arm      = w[SB_ARM];
        c.fast_clk = w[SB_FAST];
        c.psc      = w[PSC_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_setup(input setup_cfg_t c,
                                                     input logic run,
                                                     input logic evt,
                                                     input logic lock);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[PSC_W-1:0]   = c.psc;
        w[SB_FAST]     = c.fast_clk;
        w[SB_ARM]      = c.arm;
        w[SB_LOCK]     = lock;
        w[SB_EVT]      = evt;
        w[SB_RUN]      = run;
        return w;
    endfunction

    function automatic logic [DIV_W-1:0] psc_mask(input logic [PSC_W-1:0] code);
        logic [31:0] full;
        full = (32'd1 << code) - 32'd1;
        return full[DIV_W-1:0];
    endfunction

endpackage

// File: rtl/wdt_setup_reg.sv
module wdt_setup_reg
    import wdt_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_setup,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_set,
    output setup_cfg_t        cfg,
    output logic              run,
    output logic              evt,
    output logic              locked
);

    logic evt_clr;
    assign evt_clr = wr_setup && wdata[SB_EVT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            run    <= 1'b0;
            locked <= 1'b0;
        end else if (wr_setup) begin
            run <= wdata[SB_RUN];
            if (!locked) begin
                cfg    <= decode_cfg(wdata);
                locked <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          evt <= 1'b0;
        else if (evt_set) evt <= 1'b1;
        else if (evt_clr) evt <= 1'b0;
    end

    // R2: configuration frozen once locked
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cfg));

    // R8: event is sticky without a clearing write
    a_r8_evt_sticky: assert property (@(posedge clk) disable iff (rst)
        (evt && !evt_clr) |=> evt);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = psc_mask(psc);
    assign tick = run && src && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) div_q <= '0;
        else if (src)               div_q <= div_q + 1'b1;
    end

    // R5: division state only moves on source ticks
    a_r5_div_quiet: assert property (@(posedge clk) disable iff (rst)
        (run && !src && !restart) |=> $stable(div_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              arm,
    input  logic [DATA_W-1:0] cmp,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic              match
);

    logic              halted;
    logic [DATA_W-1:0] next_cnt;

    assign next_cnt = count + 1'b1;
    assign match    = tick && !wr_cnt && arm && !halted && (next_cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            halted <= 1'b0;
        end else if (wr_cnt) begin
            count  <= wdata;
            halted <= 1'b0;
        end else if (tick && !(arm && halted)) begin
            count <= next_cnt;
            if (arm && (next_cnt == cmp)) halted <= 1'b1;
        end
    end

    // R4: no tick and no write keeps the count
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(count));

    // R7: after a match the count is frozen until rewritten
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (arm && halted && !wr_cnt) |=> $stable(count));

    // R5: a tick advances by exactly one
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && !halted) |=> (count == $past(count) + 16'd1));

endmodule

// File: rtl/wdt_timer_chan.sv
module wdt_timer_chan
    import wdt_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              reset_en,
    input  logic              nmi_en,
    output logic              rst_req,
    output logic              nmi_req
);

    reg_sel_e          sel;
    logic              wr_cmp, wr_cnt, wr_setup;
    logic [DATA_W-1:0] cmp_q, cnt_q;
    setup_cfg_t        cfg;
    logic              run, evt, locked, tick, match, src;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_cmp   = bus_wr && (sel == REG_CMP);
    assign wr_cnt   = bus_wr && (sel == REG_CNT);
    assign wr_setup = bus_wr && (sel == REG_SETUP);
    assign src      = cfg.fast_clk ? 1'b1 : ref_tick;

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (wr_cmp) cmp_q <= bus_wdata;
    end

    wdt_setup_reg u_setup (
        .clk      (clk),
        .rst      (rst),
        .wr_setup (wr_setup),
        .wdata    (bus_wdata),
        .evt_set  (match),
        .cfg      (cfg),
        .run      (run),
        .evt      (evt),
        .locked   (locked)
    );

    wdt_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .src     (src),
        .restart (wr_cnt),
        .psc     (cfg.psc),
        .tick    (tick)
    );

    wdt_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .arm    (cfg.arm),
        .cmp    (cmp_q),
        .wr_cnt (wr_cnt),
        .wdata  (bus_wdata),
        .count  (cnt_q),
        .match  (match)
    );

    always_comb begin
        unique case (sel)
            REG_CMP:   bus_rdata = cmp_q;
            REG_CNT:   bus_rdata = cnt_q;
            REG_SETUP: bus_rdata = pack_setup(cfg, run, evt, locked);
            default:   bus_rdata = '0;
        endcase
    end

    assign rst_req = evt && reset_en;
    assign nmi_req = evt && nmi_en;

    // R7: an event only appears with the counter sitting on the compare value
    a_r7_evt_at_cmp: assert property (@(posedge clk) disable iff (rst)
        ($rose(evt) && !$past(wr_cmp)) |-> (cnt_q == cmp_q));

    // R11: an unarmed channel never raises the event
    a_r11_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg.arm && !evt) |=> !evt);

endmodule

// File: tb/sim_wdt_timer_chan.sv
module sim_wdt_timer_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        reset_en = 1'b0;
    logic        nmi_en = 1'b0;
    logic        rst_req, nmi_req;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    localparam logic [15:0] RUN  = 16'h8000;
    localparam logic [15:0] EVT  = 16'h4000;
    localparam logic [15:0] LOCK = 16'h1000;
    localparam logic [15:0] ARM  = 16'h0020;
    localparam logic [15:0] FAST = 16'h0010;

    always #5 clk = ~clk;

    wdt_timer_chan u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .reset_en(reset_en), .nmi_en(nmi_en),
        .rst_req(rst_req), .nmi_req(nmi_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ref_pulse();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), rv);
            chk("R1 reset readback", rv, 16'h0);
        end
        chk("R1 rst_req after reset", {15'd0, rst_req}, 16'd0);
        chk("R1 nmi_req after reset", {15'd0, nmi_req}, 16'd0);

        // R5/R7/R2 prescale sweep on the core clock
        for (int p = 0; p < 8; p++) begin
            do_reset();
            wr_reg(2'd0, 16'd3);
            wr_reg(2'd2, RUN | ARM | FAST | 16'(p));
            repeat (3 * (1 << p) - 1) @(negedge clk);
            rd_reg(2'd1, rv);
            chk($sformatf("R5 count before match psc=%0d", p), rv, 16'd2);
            rd_reg(2'd2, rv);
            chk($sformatf("R2 setup readback psc=%0d", p), rv, RUN | LOCK | ARM | FAST | 16'(p));
            @(negedge clk);
            rd_reg(2'd1, rv);
            chk($sformatf("R7 count at match psc=%0d", p), rv, 16'd3);
            rd_reg(2'd2, rv);
            chk($sformatf("R7 event set psc=%0d", p), {15'd0, rv[14]}, 16'd1);
        end
        rd_reg(2'd0, rv);
        chk("R1 compare readback", rv, 16'd3);

        // R9/R10 request gating (psc=7 channel, event pending)
        chk("R9 rst_req gated off", {15'd0, rst_req}, 16'd0);
        @(negedge clk); reset_en = 1'b1; #1;
        chk("R9 rst_req asserted", {15'd0, rst_req}, 16'd1);
        chk("R10 nmi_req gated off", {15'd0, nmi_req}, 16'd0);
        nmi_en = 1'b1; #1;
        chk("R10 nmi_req asserted", {15'd0, nmi_req}, 16'd1);

        // R7 halt at compare
        repeat (300) @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R7 counter held at compare", rv, 16'd3);

        // R8 write without clear bit keeps event
        wr_reg(2'd2, RUN);
        rd_reg(2'd2, rv);
        chk("R8 event kept without clear bit", {15'd0, rv[14]}, 16'd1);

        // R8 clear, R7 no re-fire
        wr_reg(2'd2, RUN | EVT);
        #1;
        chk("R8 event cleared", {15'd0, rst_req}, 16'd0);
        repeat (400) @(negedge clk);
        rd_reg(2'd2, rv);
        chk("R7 no re-fire after clear", {15'd0, rv[14]}, 16'd0);
        chk("R2 config unchanged after lock", rv & 16'h003F, ARM | FAST | 16'd7);
        rd_reg(2'd1, rv);
        chk("R7 still frozen", rv, 16'd3);

        // R6 counter rewrite restarts division
        wr_reg(2'd1, 16'd0);
        repeat (127) @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R6 no tick before full division", rv, 16'd0);
        @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R6 first tick after rewrite", rv, 16'd1);

        // R3/R4 run bit still writable, hold while stopped
        wr_reg(2'd2, 16'h0000);
        rd_reg(2'd2, rv);
        chk("R3 run bit cleared after lock", rv & (RUN | LOCK), LOCK);
        repeat (500) @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R4 counter held while stopped", rv, 16'd1);
        wr_reg(2'd2, RUN);
        rd_reg(2'd2, rv);
        chk("R3 run bit set again", rv & RUN, RUN);
        reset_en = 1'b0; nmi_en = 1'b0;

        // R5 reference tick source, psc=2
        do_reset();
        wr_reg(2'd0, 16'd10);
        wr_reg(2'd2, RUN | ARM | 16'd2);
        repeat (50) @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R5 no count without reference", rv, 16'd0);
        repeat (7) ref_pulse();
        rd_reg(2'd1, rv);
        chk("R5 seven reference ticks", rv, 16'd1);
        ref_pulse();
        rd_reg(2'd1, rv);
        chk("R5 eight reference ticks", rv, 16'd2);

        // R11 unarmed wrap
        do_reset();
        wr_reg(2'd0, 16'd5);
        wr_reg(2'd2, RUN | FAST);
        wr_reg(2'd1, 16'hFFFE);
        rd_reg(2'd1, rv);
        chk("R6 loaded value", rv, 16'hFFFE);
        @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R11 reaches top", rv, 16'hFFFF);
        @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R11 wraps to zero", rv, 16'h0000);
        repeat (6) @(negedge clk);
        rd_reg(2'd1, rv);
        chk("R11 runs past compare", rv, 16'd6);
        rd_reg(2'd2, rv);
        chk("R11 no event when unarmed", {15'd0, rv[14]}, 16'd0);
        rd_reg(2'd3, rv);
        chk("R1 unused address reads zero", rv, 16'd0);

        finish_run();
    end

endmodule